// File: doc/BRIEF.md
# Two-Level Translation Buffer with Command Registers

This block holds virtual-to-physical page translations in two levels. The main level is a set-associative array with 128 sets and 2 ways in the default configuration. In front of it sits a small, fully associative micro level with 8 entries, held in flops. Software fills and maintains the main level only. It stages an entry in two data registers, points at a slot with an index register, and then issues a command: probe, get-index, write, write-without-micro-clear, read, or micro-clear. Each command takes a fixed two cycles and ends with a done pulse.

A lookup port translates a virtual page number plus address-space ID. The micro level is searched first. On a micro miss the main level is searched, and a main hit refills the micro level in round-robin order. Software can write the main level without clearing the micro level. A translation evicted from the main level can then still be served by the micro level, which has more associativity. An explicit command clears the micro level when a mapping is really removed.

Register layout:
- Entry-tag register (sel 1): bits [31:13] are the virtual page number, bit 8 is valid, and bits [7:0] are the ASID. The set is the low 7 bits of the page number.
- Entry-data register (sel 2): bits [25:6] are the frame number and bits [5:0] are the permissions.
- Index register (sel 0): bits [7:0] are the slot, bit 31 is lookup-error and bit 30 is duplicate-error.
- Command register (sel 3): bits [2:0] hold the opcode. Probe = 1, get-index = 2, write = 3, write-without-micro-clear = 4, read = 5, micro-clear = 6.

Top module: `tlb2lvl`

## Requirements
- R1: After reset the index, entry-tag and entry-data registers read 0, done is low, the lookup port is ready, and every lookup misses because all slots are empty.
- R2: A slot index is set × WAYS + way, where the set is the low 7 bits of the virtual page number. In an empty set (page 0x00A5, set 37), get-index returns 74.
- R3: The write command stores the entry-tag and entry-data registers at the indexed slot. The read command copies that slot back into both registers, with unused bits reading 0.
- R4: The write command (opcode 3) clears every micro entry, so a translation held only there needs the longer main-level lookup afterwards.
- R5: The write-without-micro-clear command (opcode 4) stores the slot like a write but leaves the micro entries. An overwritten translation keeps hitting in one cycle with its old frame.
- R6: The micro-clear command (opcode 6) clears all micro entries and leaves the main level unchanged.
- R7: Probe searches the tag's set for a valid slot with equal page number and ASID, ignoring the tag's valid bit. On one match it loads the index and clears both error bits. On no match it sets bit 31, clears bit 30 and keeps the index field.
- R8: A write that duplicates an existing tag is accepted. A probe that then matches more than one way sets bits 31 and 30 and loads the lowest matching slot. A lookup uses the lowest matching way.
- R9: Get-index loads the lowest empty way of the tag's set. When the set is full it loads a victim way from one round-robin counter that advances only on such full-set requests.
- R10: Writing a zero tag and zero data erases a slot. Lookups of its old translation then miss, and a read returns zeros.
- R11: A micro hit raises ack and hit one cycle after the request. Otherwise ack comes two cycles after the request, with hit set and the frame and permissions of a main hit, or with hit, frame and permissions zero on a miss.
- R12: A main hit refills the micro level at a round-robin pointer. After nine distinct refills into eight entries, the first translation needs the two-cycle lookup again.
- R13: When a write or micro-clear executes on the same edge as a micro refill, the clear wins. The concurrent lookup still reports its main hit.
- R14: A write to the command register raises done exactly two cycles later for one cycle. Opcodes 0 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 index, 1 entry-tag, 2 entry-data, 3 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (command reads 0) |
| cmd_done | output | 1 | Command completion pulse |
| lk_req | input | 1 | Lookup request, taken when lk_ready is high |
| lk_vpn | input | 19 | Lookup virtual page number |
| lk_asid | input | 8 | Lookup address-space ID |
| lk_ready | output | 1 | Lookup port can take a request |
| lk_ack | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Lookup found a translation |
| lk_pfn | output | 20 | Translated frame number |
| lk_perm | output | 6 | Permission bits of the translation |

## Verification
Two events can land on the same clock edge: a command that clears the micro level, and a micro refill from a lookup that reached the main level. The bench provokes this by raising the micro-clear command write and a lookup request in the same cycle, where the lookup misses the micro level but hits the main level. The concurrent lookup must still report its main hit with the right frame. The next lookup of the same page must then take the two-cycle path, which shows that the refilled entry was dropped.

// File: rtl/tlb2lvl.sv
module tlb2lvl #(
  parameter int SETS   = 128,
  parameter int WAYS   = 2,
  parameter int UENT   = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_sel,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                cmd_done,
  input  logic                lk_req,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [ASID_W-1:0]   lk_asid,
  output logic                lk_ready,
  output logic                lk_ack,
  output logic                lk_hit,
  output logic [PFN_W-1:0]    lk_pfn,
  output logic [5:0]          lk_perm
);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int CNT_W = $clog2(WAYS + 1);
  localparam int N     = SETS * WAYS;
  localparam int IDX_W = $clog2(N);
  localparam int UP_W  = (UENT > 1) ? $clog2(UENT) : 1;
  localparam int VBIT  = ASID_W;

  localparam logic [2:0] OP_PROBE = 3'd1;
  localparam logic [2:0] OP_GETIX = 3'd2;
  localparam logic [2:0] OP_WR    = 3'd3;
  localparam logic [2:0] OP_WRNI  = 3'd4;
  localparam logic [2:0] OP_RD    = 3'd5;
  localparam logic [2:0] OP_UINV  = 3'd6;

  function automatic logic [IDX_W-1:0] ent_ix(input logic [SET_W-1:0] s, input logic [WAY_W-1:0] w);
    return IDX_W'(int'(s) * WAYS + int'(w));
  endfunction

  // software-visible registers
  logic [IDX_W-1:0] idx_q;
  logic             err_q, dup_q;
  logic [31:0]      pd0_q, pd1_q;
  logic [2:0]       op_q;
  logic             op_pend;
  logic [WAY_W-1:0] vic_q;

  // main level
  logic [N-1:0]      m_val;
  logic [VPN_W-1:0]  m_vpn  [N];
  logic [ASID_W-1:0] m_asid [N];
  logic [PFN_W-1:0]  m_pfn  [N];
  logic [5:0]        m_perm [N];

  // micro level
  logic [UENT-1:0]   u_val;
  logic [VPN_W-1:0]  u_vpn  [UENT];
  logic [ASID_W-1:0] u_asid [UENT];
  logic [PFN_W-1:0]  u_pfn  [UENT];
  logic [5:0]        u_perm [UENT];
  logic [UP_W-1:0]   u_ptr, u_nxt;

  // lookup pipeline
  logic              lk_main;
  logic [VPN_W-1:0]  lq_vpn;
  logic [ASID_W-1:0] lq_asid;

  wire [VPN_W-1:0]  p_vpn  = pd0_q[31 -: VPN_W];
  wire              p_val  = pd0_q[VBIT];
  wire [ASID_W-1:0] p_asid = pd0_q[ASID_W-1:0];
  wire [SET_W-1:0]  p_set  = p_vpn[SET_W-1:0];
  wire [SET_W-1:0]  lq_set = lq_vpn[SET_W-1:0];
  wire              wr_any = op_pend && (op_q == OP_WR || op_q == OP_WRNI);
  wire              u_clr  = op_pend && (op_q == OP_WR || op_q == OP_UINV);

  assign lk_ready = !lk_main;
  assign u_nxt    = (u_ptr == UP_W'(UENT - 1)) ? '0 : u_ptr + 1'b1;

  // probe / free-slot search on the staged tag
  logic [CNT_W-1:0] pr_cnt;
  logic [WAY_W-1:0] pr_way, fr_way;
  logic             fr_ok;
  logic [IDX_W-1:0] ix_p;
  always_comb begin
    pr_cnt = '0;
    pr_way = '0;
    fr_ok  = 1'b0;
    fr_way = '0;
    ix_p   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      ix_p = ent_ix(p_set, WAY_W'(w));
      if (m_val[ix_p] && m_vpn[ix_p] == p_vpn && m_asid[ix_p] == p_asid) begin
        pr_cnt = pr_cnt + CNT_W'(1);
        pr_way = WAY_W'(w);
      end
      if (!m_val[ix_p]) begin
        fr_ok  = 1'b1;
        fr_way = WAY_W'(w);
      end
    end
  end

  // main-level search for a lookup that missed the micro level
  logic             lm_hit;
  logic [WAY_W-1:0] lm_way;
  logic [IDX_W-1:0] ix_l, lm_ix;
  always_comb begin
    lm_hit = 1'b0;
    lm_way = '0;
    ix_l   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      ix_l = ent_ix(lq_set, WAY_W'(w));
      if (m_val[ix_l] && m_vpn[ix_l] == lq_vpn && m_asid[ix_l] == lq_asid) begin
        lm_hit = 1'b1;
        lm_way = WAY_W'(w);
      end
    end
  end
  assign lm_ix = ent_ix(lq_set, lm_way);

  // micro-level search on the request inputs
  logic            u_hit_any;
  logic [UP_W-1:0] u_sel;
  always_comb begin
    u_hit_any = 1'b0;
    u_sel     = '0;
    for (int i = UENT - 1; i >= 0; i--) begin
      if (u_val[i] && u_vpn[i] == lk_vpn && u_asid[i] == lk_asid) begin
        u_hit_any = 1'b1;
        u_sel     = UP_W'(i);
      end
    end
  end

  // slot image for the read command
  logic [31:0] rd_pd0, rd_pd1;
  always_comb begin
    rd_pd0 = '0;
    rd_pd0[31 -: VPN_W]   = m_vpn[idx_q];
    rd_pd0[VBIT]          = m_val[idx_q];
    rd_pd0[ASID_W-1:0]    = m_asid[idx_q];
    rd_pd1 = '0;
    rd_pd1[6 +: PFN_W]    = m_pfn[idx_q];
    rd_pd1[5:0]           = m_perm[idx_q];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: begin
        reg_rdata[31]        = err_q;
        reg_rdata[30]        = dup_q;
        reg_rdata[IDX_W-1:0] = idx_q;
      end
      2'd1:    reg_rdata = pd0_q;
      2'd2:    reg_rdata = pd1_q;
      default: reg_rdata = '0;
    endcase
  end

  // registers and command execution
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      err_q    <= 1'b0;
      dup_q    <= 1'b0;
      pd0_q    <= '0;
      pd1_q    <= '0;
      op_q     <= '0;
      op_pend  <= 1'b0;
      cmd_done <= 1'b0;
      vic_q    <= '0;
    end else begin
      cmd_done <= op_pend;
      op_pend  <= 1'b0;
      if (reg_wr) begin
        case (reg_sel)
          2'd0: begin
            idx_q <= reg_wdata[IDX_W-1:0];
            err_q <= 1'b0;
            dup_q <= 1'b0;
          end
          2'd1:    pd0_q <= reg_wdata;
          2'd2:    pd1_q <= reg_wdata;
          default: ;
        endcase
      end
      if (op_pend) begin
        case (op_q)
          OP_PROBE: begin
            if (pr_cnt == '0) begin
              err_q <= 1'b1;
              dup_q <= 1'b0;
            end else begin
              idx_q <= ent_ix(p_set, pr_way);
              err_q <= (pr_cnt > CNT_W'(1));
              dup_q <= (pr_cnt > CNT_W'(1));
            end
          end
          OP_GETIX: begin
            idx_q <= ent_ix(p_set, fr_ok ? fr_way : vic_q);
            err_q <= 1'b0;
            dup_q <= 1'b0;
            if (!fr_ok)
              vic_q <= (vic_q == WAY_W'(WAYS - 1)) ? '0 : vic_q + 1'b1;
          end
          OP_RD: begin
            pd0_q <= rd_pd0;
            pd1_q <= rd_pd1;
          end
          default: ;
        endcase
      end
      if (reg_wr && reg_sel == 2'd3) begin
        op_q    <= reg_wdata[2:0];
        op_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_val <= '0;
    else if (wr_any) m_val[idx_q] <= p_val;
  end

  always_ff @(posedge clk) begin
    if (wr_any) begin
      m_vpn[idx_q]  <= p_vpn;
      m_asid[idx_q] <= p_asid;
      m_pfn[idx_q]  <= pd1_q[6 +: PFN_W];
      m_perm[idx_q] <= pd1_q[5:0];
    end
  end

  // lookup port and micro level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_main <= 1'b0;
      lq_vpn  <= '0;
      lq_asid <= '0;
      lk_ack  <= 1'b0;
      lk_hit  <= 1'b0;
      lk_pfn  <= '0;
      lk_perm <= '0;
      u_val   <= '0;
      u_ptr   <= '0;
    end else begin
      lk_ack <= 1'b0;
      if (lk_main) begin
        lk_main <= 1'b0;
        lk_ack  <= 1'b1;
        lk_hit  <= lm_hit;
        lk_pfn  <= lm_hit ? m_pfn[lm_ix]  : '0;
        lk_perm <= lm_hit ? m_perm[lm_ix] : '0;
        if (lm_hit) begin
          u_val[u_ptr] <= 1'b1;
          u_ptr        <= u_nxt;
        end
      end else if (lk_req) begin
        if (u_hit_any) begin
          lk_ack  <= 1'b1;
          lk_hit  <= 1'b1;
          lk_pfn  <= u_pfn[u_sel];
          lk_perm <= u_perm[u_sel];
        end else begin
          lk_main <= 1'b1;
          lq_vpn  <= lk_vpn;
          lq_asid <= lk_asid;
        end
      end
      if (u_clr) u_val <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (lk_main && lm_hit) begin
      u_vpn[u_ptr]  <= lq_vpn;
      u_asid[u_ptr] <= lq_asid;
      u_pfn[u_ptr]  <= m_pfn[lm_ix];
      u_perm[u_ptr] <= m_perm[lm_ix];
    end
  end
endmodule

// File: rtl/tlb2lvl_chk.sv
module tlb2lvl_chk #(
  parameter int UENT = 8,
  parameter int UP_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [1:0]      reg_sel,
  input logic            cmd_done,
  input logic            lk_req,
  input logic            lk_ready,
  input logic            lk_ack,
  input logic            lk_hit,
  input logic            op_pend,
  input logic [2:0]      op_q,
  input logic [UENT-1:0] u_val,
  input logic [UP_W-1:0] u_ptr,
  input logic            lk_main,
  input logic            lm_hit,
  input logic            u_hit_any
);
  a_r14_done_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd3) |=> ##1 cmd_done);

  a_r14_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |-> $past(op_pend));

  a_r4_write_clears_micro: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pend && op_q == 3'd3) |=> (u_val == '0));

  a_r6_uinv_clears_micro: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pend && op_q == 3'd6) |=> (u_val == '0));

  a_r5_wrni_keeps_micro: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pend && op_q == 3'd4 && !lk_main) |=> $stable(u_val));

  a_r13_clear_beats_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (op_pend && (op_q == 3'd3 || op_q == 3'd6) && lk_main && lm_hit) |=> (u_val == '0));

  a_r11_micro_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_ready && u_hit_any) |=> (lk_ack && lk_hit));

  a_r11_ack_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lk_ack |-> ($past(lk_req && lk_ready) || $past(lk_main)));

  a_r11_main_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    lk_main |=> !lk_main);

  a_r12_ptr_moves_on_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_main && lm_hit) |=> (u_ptr != $past(u_ptr)));

  a_r12_ptr_still_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_main && lm_hit) |=> $stable(u_ptr));
endmodule

bind tlb2lvl tlb2lvl_chk #(.UENT(UENT), .UP_W(UP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .cmd_done(cmd_done), .lk_req(lk_req), .lk_ready(lk_ready),
  .lk_ack(lk_ack), .lk_hit(lk_hit), .op_pend(op_pend), .op_q(op_q),
  .u_val(u_val), .u_ptr(u_ptr), .lk_main(lk_main), .lm_hit(lm_hit),
  .u_hit_any(u_hit_any)
);

// File: tb/tb_tlb2lvl.sv
`timescale 1ns/1ps
module tb_tlb2lvl;
  localparam int N = 256;
  localparam int UENT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_done;
  logic        lk_req = 1'b0;
  logic [18:0] lk_vpn = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_ready, lk_ack, lk_hit;
  logic [19:0] lk_pfn;
  logic [5:0]  lk_perm;

  always #2.5 clk = ~clk;

  tlb2lvl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_done(cmd_done),
    .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_ready(lk_ready),
    .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  // reference model
  bit          bm_val [N];
  bit          bm_wr  [N];
  logic [18:0] bm_vpn [N];
  logic [7:0]  bm_asid[N];
  logic [19:0] bm_pfn [N];
  logic [5:0]  bm_perm[N];
  bit          bu_val [UENT];
  logic [18:0] bu_vpn [UENT];
  logic [7:0]  bu_asid[UENT];
  logic [19:0] bu_pfn [UENT];
  logic [5:0]  bu_perm[UENT];
  int          bu_ptr = 0, bvict = 0;
  logic [31:0] b_pd0 = '0, b_pd1 = '0;
  int          b_idx = 0;
  bit          b_err = 0, b_dup = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pd0(logic [18:0] v, logic [7:0] a, bit val);
    return {v, 4'b0, val, a};
  endfunction
  function automatic logic [31:0] mk_pd1(logic [19:0] f, logic [5:0] p);
    return {6'b0, f, p};
  endfunction
  function automatic logic [31:0] idx_word();
    return {b_err, b_dup, 22'b0, 8'(b_idx)};
  endfunction

  task automatic model_cmd(int code);
    int s, cnt, first, w;
    bit found;
    s = int'(b_pd0[19:13]);
    case (code)
      1: begin
        cnt = 0; first = 0;
        for (int k = 1; k >= 0; k--)
          if (bm_val[s*2+k] && bm_vpn[s*2+k] == b_pd0[31:13] && bm_asid[s*2+k] == b_pd0[7:0]) begin
            cnt++; first = s*2+k;
          end
        if (cnt == 0) begin b_err = 1; b_dup = 0; end
        else begin b_idx = first; b_err = (cnt > 1); b_dup = (cnt > 1); end
      end
      2: begin
        found = 0; w = 0;
        for (int k = 0; k < 2; k++)
          if (!found && !bm_val[s*2+k]) begin found = 1; w = k; end
        if (!found) begin w = bvict; bvict = (bvict + 1) % 2; end
        b_idx = s*2 + w; b_err = 0; b_dup = 0;
      end
      3, 4: begin
        bm_val[b_idx] = b_pd0[8]; bm_vpn[b_idx] = b_pd0[31:13]; bm_asid[b_idx] = b_pd0[7:0];
        bm_pfn[b_idx] = b_pd1[25:6]; bm_perm[b_idx] = b_pd1[5:0]; bm_wr[b_idx] = 1;
        if (code == 3) for (int k = 0; k < UENT; k++) bu_val[k] = 0;
      end
      5: begin
        b_pd0 = mk_pd0(bm_vpn[b_idx], bm_asid[b_idx], bm_val[b_idx]);
        b_pd1 = mk_pd1(bm_pfn[b_idx], bm_perm[b_idx]);
      end
      6: for (int k = 0; k < UENT; k++) bu_val[k] = 0;
      default: ;
    endcase
  endtask

  task automatic model_look(logic [18:0] v, logic [7:0] a, output bit h, output logic [19:0] f,
                            output logic [5:0] p, output int lat);
    int s, m;
    h = 0; f = '0; p = '0; lat = 2;
    for (int k = UENT - 1; k >= 0; k--)
      if (bu_val[k] && bu_vpn[k] == v && bu_asid[k] == a) begin h = 1; f = bu_pfn[k]; p = bu_perm[k]; lat = 1; end
    if (lat == 1) return;
    s = int'(v[6:0]); m = -1;
    for (int k = 1; k >= 0; k--)
      if (bm_val[s*2+k] && bm_vpn[s*2+k] == v && bm_asid[s*2+k] == a) m = s*2+k;
    if (m >= 0) begin
      h = 1; f = bm_pfn[m]; p = bm_perm[m];
      bu_val[bu_ptr] = 1; bu_vpn[bu_ptr] = v; bu_asid[bu_ptr] = a;
      bu_pfn[bu_ptr] = f; bu_perm[bu_ptr] = p;
      bu_ptr = (bu_ptr + 1) % UENT;
    end
  endtask

  task automatic wreg(int sel, logic [31:0] d);
    reg_wr = 1; reg_sel = 2'(sel); reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
    case (sel)
      0: begin b_idx = int'(d[7:0]); b_err = 0; b_dup = 0; end
      1: b_pd0 = d;
      2: b_pd1 = d;
      default: ;
    endcase
  endtask

  task automatic cmd(int code, string tag);
    reg_wr = 1; reg_sel = 2'd3; reg_wdata = code;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
    chk({tag, " R14 done early"}, 32'(cmd_done), 0);
    @(posedge clk); @(negedge clk);
    chk({tag, " R14 done"}, 32'(cmd_done), 1);
    model_cmd(code);
  endtask

  task automatic rdchk(int sel, logic [31:0] exp, string tag);
    reg_sel = 2'(sel); #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic look(logic [18:0] v, logic [7:0] a, string tag);
    bit eh; logic [19:0] ef; logic [5:0] ep; int el, lat;
    model_look(v, a, eh, ef, ep, el);
    lk_req = 1; lk_vpn = v; lk_asid = a;
    @(posedge clk); @(negedge clk);
    lk_req = 0;
    if (lk_ack) lat = 1;
    else begin @(posedge clk); @(negedge clk); lat = lk_ack ? 2 : 0; end
    chk({tag, " latency"}, lat, el);
    chk({tag, " hit"}, 32'(lk_hit), 32'(eh));
    chk({tag, " frame"}, 32'(lk_pfn), 32'(ef));
    chk({tag, " perm"}, 32'(lk_perm), 32'(ep));
  endtask

  task automatic install(logic [18:0] v, logic [7:0] a, logic [19:0] f, logic [5:0] p, int wc, string tag);
    wreg(1, mk_pd0(v, a, 1));
    wreg(2, mk_pd1(f, p));
    cmd(2, tag);
    cmd(wc, tag);
  endtask

  task automatic collide(logic [18:0] v, logic [7:0] a);
    bit eh; logic [19:0] ef; logic [5:0] ep; int el;
    model_look(v, a, eh, ef, ep, el);
    reg_wr = 1; reg_sel = 2'd3; reg_wdata = 32'd6;
    lk_req = 1; lk_vpn = v; lk_asid = a;
    @(posedge clk); @(negedge clk);
    reg_wr = 0; lk_req = 0;
    chk("R13 no early ack", 32'(lk_ack), 0);
    @(posedge clk); @(negedge clk);
    chk("R13 concurrent ack", 32'(lk_ack), 1);
    chk("R13 concurrent hit", 32'(lk_hit), 32'(eh));
    chk("R13 concurrent frame", 32'(lk_pfn), 32'(ef));
    chk("R13 done", 32'(cmd_done), 1);
    model_cmd(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [18:0] va, vb, vd, ve;
    void'($urandom(32'h1A2B3C4D));
    va = 19'h000A5; vb = 19'h010A5; vd = 19'h030A5; ve = 19'h00011;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1
    rdchk(0, 0, "R1 index reg"); rdchk(1, 0, "R1 tag reg"); rdchk(2, 0, "R1 data reg");
    chk("R1 done low", 32'(cmd_done), 0);
    chk("R1 ready", 32'(lk_ready), 1);
    look(19'h5, 8'd1, "R1 empty lookup");

    // R2 / R9
    install(va, 8'd3, 20'h12345, 6'h2D, 3, "R2");
    rdchk(0, 32'd74, "R2 set-way index");
    install(vb, 8'd3, 20'h0ABCD, 6'h15, 3, "R9");
    rdchk(0, 32'd75, "R9 second free way");
    wreg(1, mk_pd0(19'h020A5, 8'd3, 1));
    cmd(2, "R9"); rdchk(0, 32'd74, "R9 victim 0");
    cmd(2, "R9"); rdchk(0, 32'd75, "R9 victim 1");
    cmd(2, "R9"); rdchk(0, 32'd74, "R9 victim wraps");

    // R3
    wreg(0, 32'd75); cmd(5, "R3");
    rdchk(1, mk_pd0(vb, 8'd3, 1), "R3 read tag");
    rdchk(2, mk_pd1(20'h0ABCD, 6'h15), "R3 read data");

    // R7
    wreg(1, mk_pd0(va, 8'd3, 0)); cmd(1, "R7");
    rdchk(0, 32'd74, "R7 probe match");
    wreg(1, mk_pd0(va, 8'd4, 1)); cmd(1, "R7");
    rdchk(0, {1'b1, 1'b0, 22'b0, 8'd74}, "R7 probe miss");

    // R11
    look(va, 8'd3, "R11 main hit");
    look(va, 8'd3, "R11 micro hit");

    // R5
    wreg(0, 32'd74); wreg(1, mk_pd0(vd, 8'd3, 1)); wreg(2, mk_pd1(20'h77777, 6'h3F));
    cmd(4, "R5");
    look(va, 8'd3, "R5 stale micro hit");
    look(vd, 8'd3, "R5 new entry");

    // R6
    cmd(6, "R6");
    look(va, 8'd3, "R6 stale gone");
    look(vb, 8'd3, "R6 main intact");

    // R4
    look(vb, 8'd3, "R4 before write");
    install(ve, 8'd3, 20'h00E01, 6'h07, 3, "R4");
    look(vb, 8'd3, "R4 after write");

    // R8
    wreg(0, 32'd35); wreg(1, mk_pd0(ve, 8'd3, 1)); wreg(2, mk_pd1(20'h00E02, 6'h01));
    cmd(3, "R8");
    cmd(1, "R8");
    rdchk(0, {1'b1, 1'b1, 22'b0, 8'd34}, "R8 duplicate probe");
    look(ve, 8'd3, "R8 lowest way");

    // R10
    wreg(0, 32'd34); wreg(1, 0); wreg(2, 0); cmd(3, "R10");
    wreg(0, 32'd35); wreg(1, 0); wreg(2, 0); cmd(3, "R10");
    look(ve, 8'd3, "R10 erased lookup");
    wreg(0, 32'd34); cmd(5, "R10");
    rdchk(1, 0, "R10 read tag"); rdchk(2, 0, "R10 read data");

    // R12
    for (int i = 0; i < 9; i++) install(19'h00100 + 19'(i), 8'd5, 20'h40000 + 20'(i), 6'(i), 4, "R12");
    cmd(6, "R12");
    for (int i = 0; i < 9; i++) look(19'h00100 + 19'(i), 8'd5, "R12 fill");
    look(19'h00108, 8'd5, "R12 newest kept");
    look(19'h00100, 8'd5, "R12 oldest evicted");

    // R13
    collide(19'h00101, 8'd5);
    look(19'h00101, 8'd5, "R13 refill dropped");

    // R14
    wreg(0, 32'd9); cmd(7, "R14"); cmd(0, "R14");
    rdchk(0, 32'd9, "R14 unknown opcode");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op, s, ix;
      logic [18:0] v; logic [7:0] a;
      op = $urandom_range(0, 9);
      s = $urandom_range(0, 3);
      v = 19'(($urandom_range(0, 2) << 7) | s);
      a = 8'($urandom_range(1, 2));
      case (op)
        0, 1: install(v, a, 20'($urandom), 6'($urandom), ($urandom_range(0, 1) == 1) ? 4 : 3, "R3 random write");
        2, 3, 4: look(v, a, "R11 random lookup");
        5: begin wreg(1, mk_pd0(v, a, 1)); cmd(1, "R7"); rdchk(0, idx_word(), "R7 random probe"); end
        6: begin
          ix = s*2 + $urandom_range(0, 1);
          if (bm_wr[ix]) begin
            wreg(0, ix); cmd(5, "R3");
            rdchk(1, b_pd0, "R3 random read tag"); rdchk(2, b_pd1, "R3 random read data");
          end
        end
        7: cmd(6, "R6 random clear");
        8: begin wreg(0, s*2 + $urandom_range(0, 1)); wreg(1, 0); wreg(2, 0); cmd(3, "R10 random erase"); end
        default: begin wreg(1, mk_pd0(v, a, 1)); cmd(2, "R9"); rdchk(0, idx_word(), "R9 random get-index"); end
      endcase
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule